// File: doc/BRIEF.md
# Two-Channel Fan Tachometer Capture Timer

This block measures fan speed on two independent channels. Each channel owns a 16-bit counter that starts at all-ones and steps down once per prescaled tick. When the tachometer input of a channel shows a rising edge, the current count is latched into that channel's capture register, and the counter restarts from all-ones on the following tick. The interval between two tachometer edges, and so the fan speed, is therefore encoded as the distance of the captured value from 0xFFFF.

A measurement can also end in two other ways. The counter can run down to zero with no edge (underflow), or a compare unit can fire against a programmable limit. The compare unit has three modes: fire at once, fire when the count reaches the limit, or fire once the count is below the limit. Each of the three outcomes sets its own pending bit per channel. A masked OR of the pending bits drives a single interrupt line. Software reaches every control through a small byte/halfword register port. Each channel has a tick enable and a selector that picks one of two tachometer pins.

Top module: `fantach_timer`

## Requirements
- R1: After synchronous reset, every register at 0x08 to 0x1C reads as zero and `irq` is low.
- R2: Reset does not change the counters (0x00 channel A, 0x06 channel B) or the capture registers (0x02 A, 0x04 B).
- R3: The tick period is (prescale register 0x08 + 1) clocks. Bit 0 of 0x0A gates channel A's tick and bit 3 gates channel B's tick. While its bit is clear, a channel's counter holds its value.
- R4: With mode bits 2 and 5 (channel A) or 2 and 6 (channel B) of 0x0C set, a tachometer rising edge copies the count into the capture register and sets pending bit 0 (A) or 1 (B) in 0x0E. At prescale 0, two edges D clocks apart capture 0xFFFF − (D − 2).
- R5: While mode bit 2 is clear, edges change no capture register and set no pending bit.
- R6: A tick that finds the count at zero with no edge sets pending bit 2 (A) or 3 (B). The capture register is left alone, the count holds at zero for that tick, and the next tick reloads 0xFFFF.
- R7: Compare configuration 0x18 uses its low nibble for channel A (limit 0x14) and its high nibble for channel B (limit 0x16). Nibble bit 3 set means a hit as soon as the measurement runs. A hit sets pending bit 4 (A) or 5 (B).
- R8: Nibble bit 2 fires a hit when the count is at or below the limit. Loading the count with limit + 5 gives a hit visible 6 clocks later at prescale 0.
- R9: Nibble bit 1 fires a hit when the count is strictly below the limit, which is one clock later than R8. With a limit of zero it never fires.
- R10: A compare hit ends the measurement and takes priority over capture and over underflow.
- R11: `irq` is high exactly when some bit of pending register 0x0E has its bit set in enable register 0x12.
- R12: A byte write to 0x10 clears the pending bits that are written as 1 and leaves the others. Reads of 0x10 return zero.
- R13: Bit 0 of 0x1A selects tachometer pin 2 instead of pin 0 for channel A. Bit 0 of 0x1C selects pin 3 instead of pin 1 for channel B. An edge on the unselected pin has no effect.
- R14: The counters, captures and limits accept only halfword accesses, and all other registers accept only byte accesses. A write with the wrong size or an odd address is dropped, and a read of that kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_wdata | input | 16 | Write data (a byte access uses bits 7:0) |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| tach_in | input | 4 | Asynchronous tachometer pins |
| irq | output | 1 | Interrupt request |

## Verification
Captures are exercised with randomly spaced edge pairs on a random channel and pin. This shows whether the measured interval is exact and whether each result reaches the right channel's register and pending bit. Directed runs then load a counter just above the limit or just above zero. The clock on which the pending bit appears separates the at-limit mode from the below-limit mode, and separates a hit from an underflow. The immediate-hit mode combined with live edges shows that compare outranks capture. Edges on the unselected pin and with the run mode off show that nothing else moves the capture state.

// File: rtl/fantach_pkg.sv
package fantach_pkg;

    localparam int NUM_CH  = 2;
    localparam int CNT_W   = 16;
    localparam int PEND_W  = 3 * NUM_CH;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // halfword register indices (byte address / 2)
    localparam logic [3:0] IDX_CNT_A  = 4'd0;
    localparam logic [3:0] IDX_CAP_A  = 4'd1;
    localparam logic [3:0] IDX_CAP_B  = 4'd2;
    localparam logic [3:0] IDX_CNT_B  = 4'd3;
    localparam logic [3:0] IDX_PRESC  = 4'd4;
    localparam logic [3:0] IDX_CLKCTL = 4'd5;
    localparam logic [3:0] IDX_MODE   = 4'd6;
    localparam logic [3:0] IDX_PEND   = 4'd7;
    localparam logic [3:0] IDX_CLR    = 4'd8;
    localparam logic [3:0] IDX_IEN    = 4'd9;
    localparam logic [3:0] IDX_CMP_A  = 4'd10;
    localparam logic [3:0] IDX_CMP_B  = 4'd11;
    localparam logic [3:0] IDX_CMPCFG = 4'd12;
    localparam logic [3:0] IDX_SEL_A  = 4'd13;
    localparam logic [3:0] IDX_SEL_B  = 4'd14;

    localparam int MODE_RUN_BIT = 2;
    localparam int MODE_CH_BIT0 = 5;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_CAPTURE,
        OUT_UNDERFLOW,
        OUT_HIT
    } outcome_e;

    // compare nibble bits 3..1
    typedef struct packed {
        logic immediate;
        logic at_limit;
        logic below_limit;
    } cmp_mode_t;

    function automatic logic is_half_reg(input logic [3:0] idx);
        return idx inside {IDX_CNT_A, IDX_CAP_A, IDX_CAP_B, IDX_CNT_B, IDX_CMP_A, IDX_CMP_B};
    endfunction

    function automatic int clk_bit(input int ch);
        return (ch == 0) ? 0 : 3;
    endfunction

    function automatic logic compare_hit(input cmp_mode_t m,
                                         input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] lim);
        return m.immediate
            || (m.at_limit && (cnt <= lim))
            || (m.below_limit && (lim != '0) && (cnt < lim));
    endfunction

endpackage

// File: rtl/fantach_prescaler.sv
module fantach_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic             wrap;

    assign wrap = (phase_q >= div);
    assign tick = wrap;

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (wrap) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end

    // R3: with a nonzero divider, ticks never fall on back-to-back clocks
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && $stable(div)) |=> (!tick || div == '0));

endmodule

// File: rtl/fantach_edge_sync.sv
module fantach_edge_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/fantach_channel.sv
module fantach_channel
    import fantach_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         active,
    input  logic         edge_pulse,
    input  cmp_mode_t    mode,
    input  logic [W-1:0] lim,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output outcome_e     outcome
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q, cap_q;
    logic         reload_q;

    always_comb begin
        outcome = OUT_NONE;
        if (active && !reload_q) begin
            if (compare_hit(mode, CNT_W'(cnt_q), CNT_W'(lim))) outcome = OUT_HIT;
            else if (edge_pulse)                               outcome = OUT_CAPTURE;
            else if (tick && cnt_q == '0)                      outcome = OUT_UNDERFLOW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       reload_q <= 1'b0;
        else if (load)                 reload_q <= 1'b0;
        else if (outcome != OUT_NONE)  reload_q <= 1'b1;
        else if (tick)                 reload_q <= 1'b0;
    end

    // counter and capture survive reset on purpose
    always_ff @(posedge clk) begin
        if (load)
            cnt_q <= load_val;
        else if (tick && outcome == OUT_NONE)
            cnt_q <= reload_q ? TOP : cnt_q - 1'b1;
        if (outcome == OUT_CAPTURE)
            cap_q <= cnt_q;
    end

    assign cnt = cnt_q;
    assign cap = cap_q;

    // R6: a pending reload lands all-ones on the next tick
    p_reload_top_r6: assert property (@(posedge clk) disable iff (rst)
        (reload_q && tick && !load) |=> (cnt_q == TOP));
    // R6: the tick that ends a measurement does not move the count
    p_hold_on_end_r6: assert property (@(posedge clk) disable iff (rst)
        (outcome != OUT_NONE && !load) |=> $stable(cnt_q));
    // R3: no tick and no load keeps the count
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
    // R4: capture register holds the count seen at the edge
    p_capture_val_r4: assert property (@(posedge clk) disable iff (rst)
        (outcome == OUT_CAPTURE) |=> (cap_q == $past(cnt_q)));

endmodule

// File: rtl/fantach_timer.sv
module fantach_timer
    import fantach_pkg::*;
#(
    parameter int PRESC_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_half,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [3:0]  tach_in,
    output logic        irq
);
    localparam int NUM_PINS = 2 * NUM_CH;

    logic [3:0]          idx;
    logic                addr_ok, size_ok, wr_ok;
    logic [PRESC_W-1:0]  presc_q;
    logic [NUM_CH-1:0]   clk_en_q, ch_en_q, sel_q;
    logic                run_q;
    logic [PEND_W-1:0]   pend_q, ien_q, set_v, clr_v;
    logic [CNT_W-1:0]    cmp_q [NUM_CH];
    logic [7:0]          cmpcfg_q;
    logic                tick_all;
    logic [NUM_PINS-1:0] tach_rise;
    logic [CNT_W-1:0]    cnt_w [NUM_CH];
    logic [CNT_W-1:0]    cap_w [NUM_CH];
    outcome_e            outc_w [NUM_CH];
    logic [15:0]         rd_val;

    assign idx     = bus_addr[4:1];
    assign addr_ok = !bus_addr[0] && (idx <= IDX_SEL_B);
    assign size_ok = addr_ok && (bus_half == is_half_reg(idx));
    assign wr_ok   = bus_wr && size_ok;

    fantach_prescaler #(.DIV_W(PRESC_W)) i_presc (
        .clk(clk), .rst(rst), .div(presc_q), .tick(tick_all)
    );

    fantach_edge_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk(clk), .rst(rst), .pin(tach_in), .rise(tach_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic      edge_sel, ch_tick, ch_load, ch_active;
        cmp_mode_t ch_mode;

        assign edge_sel  = sel_q[c] ? tach_rise[c + NUM_CH] : tach_rise[c];
        assign ch_tick   = tick_all && clk_en_q[c];
        assign ch_active = run_q && ch_en_q[c] && clk_en_q[c];
        assign ch_load   = wr_ok && (idx == ((c == 0) ? IDX_CNT_A : IDX_CNT_B));
        assign ch_mode   = cmp_mode_t'(cmpcfg_q[4*c+1 +: 3]);

        fantach_channel #(.W(CNT_W)) i_ch (
            .clk(clk), .rst(rst), .tick(ch_tick), .active(ch_active),
            .edge_pulse(edge_sel), .mode(ch_mode), .lim(cmp_q[c]),
            .load(ch_load), .load_val(bus_wdata),
            .cnt(cnt_w[c]), .cap(cap_w[c]), .outcome(outc_w[c])
        );
    end

    always_comb begin
        set_v = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            set_v[c]            = (outc_w[c] == OUT_CAPTURE);
            set_v[NUM_CH + c]   = (outc_w[c] == OUT_UNDERFLOW);
            set_v[2*NUM_CH + c] = (outc_w[c] == OUT_HIT);
        end
    end

    assign clr_v = (wr_ok && idx == IDX_CLR) ? bus_wdata[PEND_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q  <= '0;
            clk_en_q <= '0;
            run_q    <= 1'b0;
            ch_en_q  <= '0;
            pend_q   <= '0;
            ien_q    <= '0;
            cmpcfg_q <= '0;
            sel_q    <= '0;
            for (int c = 0; c < NUM_CH; c++) cmp_q[c] <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | set_v;
            if (wr_ok) begin
                case (idx)
                    IDX_PRESC:  presc_q <= bus_wdata[PRESC_W-1:0];
                    IDX_CLKCTL: for (int c = 0; c < NUM_CH; c++) clk_en_q[c] <= bus_wdata[clk_bit(c)];
                    IDX_MODE: begin
                        run_q <= bus_wdata[MODE_RUN_BIT];
                        for (int c = 0; c < NUM_CH; c++) ch_en_q[c] <= bus_wdata[MODE_CH_BIT0 + c];
                    end
                    IDX_IEN:    ien_q    <= bus_wdata[PEND_W-1:0];
                    IDX_CMP_A:  cmp_q[0] <= bus_wdata;
                    IDX_CMP_B:  cmp_q[1] <= bus_wdata;
                    IDX_CMPCFG: cmpcfg_q <= bus_wdata[7:0];
                    IDX_SEL_A:  sel_q[0] <= bus_wdata[0];
                    IDX_SEL_B:  sel_q[1] <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (idx)
            IDX_CNT_A:  rd_val = cnt_w[0];
            IDX_CAP_A:  rd_val = cap_w[0];
            IDX_CAP_B:  rd_val = cap_w[1];
            IDX_CNT_B:  rd_val = cnt_w[1];
            IDX_PRESC:  rd_val[PRESC_W-1:0] = presc_q;
            IDX_CLKCTL: for (int c = 0; c < NUM_CH; c++) rd_val[clk_bit(c)] = clk_en_q[c];
            IDX_MODE: begin
                rd_val[MODE_RUN_BIT] = run_q;
                for (int c = 0; c < NUM_CH; c++) rd_val[MODE_CH_BIT0 + c] = ch_en_q[c];
            end
            IDX_PEND:   rd_val[PEND_W-1:0] = pend_q;
            IDX_IEN:    rd_val[PEND_W-1:0] = ien_q;
            IDX_CMP_A:  rd_val = cmp_q[0];
            IDX_CMP_B:  rd_val = cmp_q[1];
            IDX_CMPCFG: rd_val[7:0] = cmpcfg_q;
            IDX_SEL_A:  rd_val[0] = sel_q[0];
            IDX_SEL_B:  rd_val[0] = sel_q[1];
            default:    rd_val = '0;
        endcase
        bus_rdata = size_ok ? rd_val : 16'h0000;
    end

    assign irq = |(pend_q & ien_q);

    // R5: with the run mode off no pending bit rises
    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> ((pend_q & ~$past(pend_q)) == '0));
    // R12: bits written as 1 to the clear register drop when nothing new sets them
    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && idx == IDX_CLR && set_v == '0) |=> ((pend_q & $past(bus_wdata[PEND_W-1:0])) == '0));
    // R11: no pending bit means no interrupt
    p_irq_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> !irq);
    // R1: the cycle after reset the interrupt is low
    p_reset_irq_r1: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: tb/test_fantach_timer.sv
module test_fantach_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  tach_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    fantach_timer i_fantach_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tach_in(tach_in), .irq(irq)
    );

    function automatic logic [15:0] exp_capture(input int d);
        return 16'(32'hFFFF - (d - 2));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic half, input logic [15:0] d);
        bus_addr = a; bus_half = half; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic half, output logic [15:0] d);
        bus_addr = a; bus_half = half; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_pair(input int pin, input int d);
        tach_in[pin] = 1'b1;
        repeat (3) @(negedge clk);
        tach_in[pin] = 1'b0;
        repeat (d - 3) @(negedge clk);
        tach_in[pin] = 1'b1;
        repeat (3) @(negedge clk);
        tach_in[pin] = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, v0, v1, snap;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state of configuration registers
        for (int a = 8; a <= 28; a += 2) begin
            rd(5'(a), 1'b0, v);
            chk($sformatf("R1 reg %0h after reset", a), v, 0);
        end
        chk("R1 irq after reset", irq, 0);

        // R3 frozen counters and per-channel clock gate
        wr(5'h00, 1'b1, 16'h1234);
        wr(5'h06, 1'b1, 16'h5678);
        repeat (20) @(negedge clk);
        rd(5'h00, 1'b1, v);
        chk("R3 A frozen with gate clear", v, 16'h1234);
        wr(5'h0A, 1'b0, 16'h0001);
        rd(5'h00, 1'b1, v0);
        repeat (10) @(negedge clk);
        rd(5'h00, 1'b1, v1);
        chk("R3 A counts one per clock at prescale 0", v0 - v1, 10);
        rd(5'h06, 1'b1, v);
        chk("R3 B frozen while bit 3 clear", v, 16'h5678);
        for (int p = 1; p <= 5; p += 2) begin
            wr(5'h08, 1'b0, 16'(p));
            repeat (p + 1) @(negedge clk);
            rd(5'h00, 1'b1, v0);
            repeat (4 * (p + 1)) @(negedge clk);
            rd(5'h00, 1'b1, v1);
            chk($sformatf("R3 prescale %0d step", p), v0 - v1, 4);
        end
        wr(5'h08, 1'b0, 16'h0000);
        wr(5'h0A, 1'b0, 16'h0009);
        wr(5'h0C, 1'b0, 16'h0064);

        // R4 random captures on random channel and pin
        for (int it = 0; it < 16; it++) begin
            int ch, sel, d, pin;
            ch  = int'($urandom % 2);
            sel = int'($urandom % 2);
            d   = 8 + int'($urandom % 500);
            pin = ch + 2 * sel;
            wr(ch == 0 ? 5'h1A : 5'h1C, 1'b0, 16'(sel));
            wr(5'h00, 1'b1, 16'hFFFF);
            wr(5'h06, 1'b1, 16'hFFFF);
            wr(5'h10, 1'b0, 16'h003F);
            pulse_pair(pin, d);
            rd(ch == 0 ? 5'h02 : 5'h04, 1'b1, v);
            chk($sformatf("R4 capture ch%0d pin%0d D=%0d", ch, pin, d), v, exp_capture(d));
            rd(5'h0E, 1'b0, v);
            chk("R4 capture pending bit", v[ch], 1);
        end
        wr(5'h1A, 1'b0, 16'h0000);
        wr(5'h1C, 1'b0, 16'h0000);

        // R13 unselected pin ignored, selected pin captured
        wr(5'h1A, 1'b0, 16'h0001);
        wr(5'h10, 1'b0, 16'h003F);
        rd(5'h02, 1'b1, snap);
        pulse_pair(0, 30);
        rd(5'h02, 1'b1, v);
        chk("R13 pin 0 ignored when pin 2 selected", v, snap);
        rd(5'h0E, 1'b0, v);
        chk("R13 no pending from unselected pin", v[0], 0);
        pulse_pair(2, 40);
        rd(5'h02, 1'b1, v);
        chk("R13 pin 2 captured", v, exp_capture(40));
        wr(5'h1A, 1'b0, 16'h0000);

        // R5 run mode off
        wr(5'h0C, 1'b0, 16'h0060);
        wr(5'h10, 1'b0, 16'h003F);
        rd(5'h02, 1'b1, snap);
        pulse_pair(0, 25);
        rd(5'h02, 1'b1, v);
        chk("R5 no capture with run mode off", v, snap);
        rd(5'h0E, 1'b0, v);
        chk("R5 no pending with run mode off", v, 0);
        wr(5'h0C, 1'b0, 16'h0064);

        // R6 underflow timing
        wr(5'h06, 1'b1, 16'hFFFF);
        wr(5'h10, 1'b0, 16'h003F);
        rd(5'h02, 1'b1, snap);
        wr(5'h00, 1'b1, 16'h0003);
        repeat (3) @(negedge clk);
        rd(5'h00, 1'b1, v);
        chk("R6 count reaches zero", v, 0);
        rd(5'h0E, 1'b0, v);
        chk("R6 no underflow before wrap tick", v[2], 0);
        @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R6 underflow pending", v[2], 1);
        rd(5'h00, 1'b1, v);
        chk("R6 count held on underflow tick", v, 0);
        @(negedge clk);
        rd(5'h00, 1'b1, v);
        chk("R6 reload to all ones", v, 16'hFFFF);
        rd(5'h02, 1'b1, v);
        chk("R6 capture untouched", v, snap);

        // R11 interrupt masking
        chk("R11 irq low with enables clear", irq, 0);
        wr(5'h12, 1'b0, 16'h0004);
        chk("R11 irq high with enabled pending", irq, 1);
        wr(5'h12, 1'b0, 16'h0001);
        chk("R11 irq low when other bit enabled", irq, 0);
        wr(5'h12, 1'b0, 16'h0004);

        // R12 selective clear and write-only read
        wr(5'h10, 1'b0, 16'h0001);
        rd(5'h0E, 1'b0, v);
        chk("R12 unwritten bit stays", v[2], 1);
        wr(5'h10, 1'b0, 16'h0004);
        rd(5'h0E, 1'b0, v);
        chk("R12 written bit cleared", v[2], 0);
        chk("R11 irq drops after clear", irq, 0);
        rd(5'h10, 1'b0, v);
        chk("R12 clear register reads zero", v, 0);
        wr(5'h12, 1'b0, 16'h0000);

        // R8 at-limit compare timing
        wr(5'h14, 1'b1, 16'h0100);
        wr(5'h18, 1'b0, 16'h0004);
        wr(5'h10, 1'b0, 16'h003F);
        wr(5'h00, 1'b1, 16'h0105);
        repeat (5) @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R8 no hit above limit", v[4], 0);
        @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R8 hit at limit", v[4], 1);

        // R9 below-limit compare timing
        wr(5'h18, 1'b0, 16'h0002);
        wr(5'h10, 1'b0, 16'h003F);
        wr(5'h00, 1'b1, 16'h0105);
        repeat (6) @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R9 no hit at limit", v[4], 0);
        @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R9 hit below limit", v[4], 1);

        // R9 zero limit ignored, underflow instead
        wr(5'h14, 1'b1, 16'h0000);
        wr(5'h10, 1'b0, 16'h003F);
        wr(5'h00, 1'b1, 16'h0002);
        repeat (5) @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R9 zero limit gives no hit", v[4], 0);
        chk("R9 zero limit ends in underflow", v[2], 1);

        // R7 and R10 immediate hit beats capture
        wr(5'h18, 1'b0, 16'h0008);
        wr(5'h10, 1'b0, 16'h003F);
        rd(5'h02, 1'b1, snap);
        wr(5'h10, 1'b0, 16'h003F);
        pulse_pair(0, 30);
        rd(5'h02, 1'b1, v);
        chk("R10 capture suppressed by hit", v, snap);
        rd(5'h0E, 1'b0, v);
        chk("R10 no capture pending", v[0], 0);
        chk("R7 immediate hit channel A", v[4], 1);
        wr(5'h18, 1'b0, 16'h0080);
        wr(5'h10, 1'b0, 16'h003F);
        repeat (5) @(negedge clk);
        rd(5'h0E, 1'b0, v);
        chk("R7 immediate hit channel B", v[5], 1);
        chk("R7 channel A nibble now idle", v[4], 0);
        wr(5'h18, 1'b0, 16'h0000);

        // R14 access size filtering
        wr(5'h0A, 1'b0, 16'h0000);
        wr(5'h00, 1'b1, 16'hABCD);
        wr(5'h00, 1'b0, 16'h0011);
        rd(5'h00, 1'b1, v);
        chk("R14 byte write to counter dropped", v, 16'hABCD);
        rd(5'h00, 1'b0, v);
        chk("R14 byte read of counter is zero", v, 0);
        wr(5'h0C, 1'b1, 16'h0000);
        rd(5'h0C, 1'b0, v);
        chk("R14 halfword write to mode dropped", v, 16'h0064);
        rd(5'h0C, 1'b1, v);
        chk("R14 halfword read of mode is zero", v, 0);
        rd(5'h0D, 1'b0, v);
        chk("R14 odd address reads zero", v, 0);

        // R2 reset keeps counter and capture
        wr(5'h00, 1'b1, 16'h2468);
        rd(5'h02, 1'b1, snap);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(5'h00, 1'b1, v);
        chk("R2 counter kept over reset", v, 16'h2468);
        rd(5'h02, 1'b1, v);
        chk("R2 capture kept over reset", v, snap);
        rd(5'h0C, 1'b0, v);
        chk("R1 mode cleared by reset", v, 0);
        chk("R1 irq low after second reset", irq, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule